// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the external bus engine of a 16-bit core with a 20-bit physical address space. The core issues one request at a time. A request is either a memory or an I/O access, either a read or a write, and carries an address, a two-bit segment tag and write data. The sequencer turns each accepted request into a bus cycle of states T1, T2, T3, any number of wait states, and T4. The low address bits and the data share one set of lines. The upper address lines carry a status code once the address phase has ended.

The block drives an address-latch strobe, a memory/I/O select, a transmit/receive direction, and active-low read, write and data-enable strobes. It samples a ready input to stretch the cycle. At the end of a read it returns the captured data together with a one-clock completion pulse. When no request is waiting, it sits in idle states with every strobe inactive and the shared lines released.

Top module: `busseq_top`

## Requirements
- R1: After reset and in every idle state, req_ready_o is 1, ale_o is 0, rd_no, wr_no and den_no are 1, bus_ad_oe_o is 0 and done_o is 0. An asynchronous reset in the middle of a cycle returns the block to this state at once.
- R2: A request accepted at a clock edge gives T1 in the next cycle. With N wait states, done_o is 1 for exactly one cycle, the (4+N)-th after acceptance (T4), and is 0 in all other cycles.
- R3: In T1, and only in T1, ale_o is 1. During T1, bus_ad_oe_o is 1, bus_ad_o carries address bits 15:0, and for a memory cycle bus_as_o carries address bits 19:16.
- R4: m_io_o is 1 for a memory cycle and 0 for an I/O cycle, from T1 through T4. In an I/O cycle, bus_as_o is 0 during T1, so only the low 16 address bits appear.
- R5: From T2 through T4, bus_as_o carries the status code. Bit 3 is always 0. Bit 2 is the interrupt-enable flag taken with the request. Bits 1:0 are the segment tag (0 extra, 1 stack, 2 code, 3 data).
- R6: In a read cycle, rd_no is 0 from T2 through T3 and any wait states, and 1 in T1 and T4. wr_no stays 1 throughout. dt_r_o is 0 from T1 through T4, and bus_ad_oe_o is 0 from T2 through T4.
- R7: In a write cycle, wr_no is 0 from T2 through T3 and any wait states, and 1 in T1 and T4. rd_no stays 1 throughout. dt_r_o is 1 throughout the cycle, and bus_ad_o carries the write data with bus_ad_oe_o at 1 from T2 through T4.
- R8: den_no is 0 from T2 to the last T3 or wait state of a cycle, and 1 in T1 and T4.
- R9: ready_i is sampled at the end of T3 and at the end of each wait state. A 0 adds a further wait state, with the strobes held. A 1 moves the cycle to T4.
- R10: Read data on bus_ad_i is captured at the edge that leaves the last T3 or wait state. It is presented on rdata_o during T4 and holds until the next read completes, whatever bus_ad_i does from T4 onwards.
- R11: req_ready_o is 0 from T1 through T4. A request held valid across a cycle is taken only in the idle state that follows T4. Changes to the request inputs during a cycle do not affect that cycle's outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request pending from the core |
| req_ready_o | output | 1 | Sequencer idle, takes the request at this edge |
| req_is_mem_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| req_is_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 20 | Physical address |
| req_seg_i | input | 2 | Segment tag for the status code |
| req_if_flag_i | input | 1 | Interrupt-enable flag for the status code |
| req_wdata_i | input | 16 | Write data |
| ready_i | input | 1 | Bus ready, 0 inserts wait states |
| bus_ad_o | output | 16 | Shared address/data lines, outgoing value |
| bus_ad_oe_o | output | 1 | Drive enable for bus_ad_o |
| bus_ad_i | input | 16 | Shared address/data lines, incoming value |
| bus_as_o | output | 4 | Upper address in T1, status afterwards |
| ale_o | output | 1 | Address latch strobe |
| m_io_o | output | 1 | 1 = memory, 0 = I/O |
| dt_r_o | output | 1 | 1 = transmit (write), 0 = receive (read) |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| den_no | output | 1 | Data transceiver enable, active low |
| rdata_o | output | 16 | Captured read data |
| done_o | output | 1 | One-cycle completion pulse in T4 |

## Verification
The bench builds the block with its default parameters: 20 address bits, 16 shared lines and a 16-bit I/O space. With these values the upper four lines fit the full status code, and I/O addresses with nonzero bits above 15 test the zeroing of the upper lines. The wait-state count in the vectors goes up to three. This exercises the T3 exit, a single wait, and a stretch in which ready stays low across several samples. A request held valid across a cycle and a reset in the middle of a cycle are also driven.

// File: rtl/busseq_pkg.sv
package busseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_state_e;
endpackage

// File: rtl/busseq_fsm.sv
module busseq_fsm
  import busseq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic       ready_i,
  output bus_state_e state_o,
  output logic       accept_o,
  output logic       capture_o
);
  bus_state_e state_q, state_d;

  assign accept_o  = (state_q == ST_IDLE) && req_valid_i;
  assign capture_o = ((state_q == ST_T3) || (state_q == ST_TW)) && ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) state_d = ST_T1;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3:   state_d = ready_i ? ST_T4 : ST_TW;
      ST_TW:   state_d = ready_i ? ST_T4 : ST_TW;
      ST_T4:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/busseq_latch.sv
module busseq_latch #(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int IO_ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic              is_mem_i,
  input  logic              is_write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        seg_i,
  input  logic              if_flag_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bus_ad_i,
  output logic              is_mem_o,
  output logic              is_write_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        seg_o,
  output logic              if_flag_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] eff_addr;

  // I/O space keeps only the low address bits
  assign eff_addr = is_mem_i ? addr_i : ADDR_W'(addr_i[IO_ADDR_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is_mem_o   <= 1'b0;
      is_write_o <= 1'b0;
      addr_o     <= '0;
      seg_o      <= '0;
      if_flag_o  <= 1'b0;
      wdata_o    <= '0;
    end else if (accept_i) begin
      is_mem_o   <= is_mem_i;
      is_write_o <= is_write_i;
      addr_o     <= eff_addr;
      seg_o      <= seg_i;
      if_flag_o  <= if_flag_i;
      wdata_o    <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       rdata_o <= '0;
    else if (capture_i && !is_write_o) rdata_o <= bus_ad_i;
  end
endmodule

// File: rtl/busseq_drive.sv
module busseq_drive
  import busseq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  bus_state_e        state_i,
  input  logic              is_mem_i,
  input  logic              is_write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        seg_i,
  input  logic              if_flag_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] bus_ad_o,
  output logic              bus_ad_oe_o,
  output logic [HI_W-1:0]   bus_as_o,
  output logic              ale_o,
  output logic              m_io_o,
  output logic              dt_r_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              den_no
);
  logic in_t1, in_strobe, in_data, active;

  assign in_t1     = (state_i == ST_T1);
  assign in_strobe = (state_i == ST_T2) || (state_i == ST_T3) || (state_i == ST_TW);
  assign in_data   = in_strobe || (state_i == ST_T4);
  assign active    = (state_i != ST_IDLE);

  assign ale_o       = in_t1;
  assign m_io_o      = active && is_mem_i;
  assign dt_r_o      = active ? is_write_i : 1'b1;
  assign rd_no       = !(in_strobe && !is_write_i);
  assign wr_no       = !(in_strobe && is_write_i);
  assign den_no      = !in_strobe;
  assign bus_ad_oe_o = in_t1 || (in_data && is_write_i);

  always_comb begin
    bus_ad_o = '0;
    bus_as_o = '0;
    if (in_t1) begin
      bus_ad_o = addr_i[DATA_W-1:0];
      bus_as_o = addr_i[ADDR_W-1:DATA_W];
    end else if (in_data) begin
      if (is_write_i) bus_ad_o = wdata_i;
      // top status bit is zero by the extension
      bus_as_o = HI_W'({if_flag_i, seg_i});
    end
  end
endmodule

// File: rtl/busseq_top.sv
module busseq_top
  import busseq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int IO_ADDR_W = 16,
  localparam int HI_W     = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_is_mem_i,
  input  logic              req_is_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_seg_i,
  input  logic              req_if_flag_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              ready_i,
  output logic [DATA_W-1:0] bus_ad_o,
  output logic              bus_ad_oe_o,
  input  logic [DATA_W-1:0] bus_ad_i,
  output logic [HI_W-1:0]   bus_as_o,
  output logic              ale_o,
  output logic              m_io_o,
  output logic              dt_r_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              den_no,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  bus_state_e        state;
  logic              accept, capture;
  logic              lat_mem, lat_wr, lat_if;
  logic [ADDR_W-1:0] lat_addr;
  logic [1:0]        lat_seg;
  logic [DATA_W-1:0] lat_wdata;

  busseq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .ready_i     (ready_i),
    .state_o     (state),
    .accept_o    (accept),
    .capture_o   (capture)
  );

  busseq_latch #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .IO_ADDR_W (IO_ADDR_W)
  ) u_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .capture_i  (capture),
    .is_mem_i   (req_is_mem_i),
    .is_write_i (req_is_write_i),
    .addr_i     (req_addr_i),
    .seg_i      (req_seg_i),
    .if_flag_i  (req_if_flag_i),
    .wdata_i    (req_wdata_i),
    .bus_ad_i   (bus_ad_i),
    .is_mem_o   (lat_mem),
    .is_write_o (lat_wr),
    .addr_o     (lat_addr),
    .seg_o      (lat_seg),
    .if_flag_o  (lat_if),
    .wdata_o    (lat_wdata),
    .rdata_o    (rdata_o)
  );

  busseq_drive #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_drive (
    .state_i     (state),
    .is_mem_i    (lat_mem),
    .is_write_i  (lat_wr),
    .addr_i      (lat_addr),
    .seg_i       (lat_seg),
    .if_flag_i   (lat_if),
    .wdata_i     (lat_wdata),
    .bus_ad_o    (bus_ad_o),
    .bus_ad_oe_o (bus_ad_oe_o),
    .bus_as_o    (bus_as_o),
    .ale_o       (ale_o),
    .m_io_o      (m_io_o),
    .dt_r_o      (dt_r_o),
    .rd_no       (rd_no),
    .wr_no       (wr_no),
    .den_no      (den_no)
  );

  assign req_ready_o = (state == ST_IDLE);
  assign done_o      = (state == ST_T4);
endmodule

// File: rtl/busseq_chk.sv
module busseq_chk #(
  parameter int HI_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_ready_o,
  input logic            ready_i,
  input logic            bus_ad_oe_o,
  input logic [HI_W-1:0] bus_as_o,
  input logic            ale_o,
  input logic            dt_r_o,
  input logic            rd_no,
  input logic            wr_no,
  input logic            den_no,
  input logic            done_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (rd_no && wr_no && den_no && !ale_o && !bus_ad_oe_o && !done_o));

  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));

  a_r3_ale_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> (!ale_o && !req_ready_o));

  a_r3_ale_drives_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (bus_ad_oe_o && rd_no && wr_no && den_no));

  a_r5_s6_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && !ale_o) |-> !bus_as_o[HI_W-1]);

  a_r6_read_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (!bus_ad_oe_o && !dt_r_o && wr_no));

  a_r7_write_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> (bus_ad_oe_o && dt_r_o && rd_no));

  a_r8_den_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !den_no |-> (rd_no != wr_no));

  a_r9_rd_held_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no && !ready_i) |=> !rd_no);

  a_r9_wr_held_in_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_no && !ready_i) |=> !wr_no);
endmodule

bind busseq_top busseq_chk #(.HI_W(HI_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .ready_i     (ready_i),
  .bus_ad_oe_o (bus_ad_oe_o),
  .bus_as_o    (bus_as_o),
  .ale_o       (ale_o),
  .dt_r_o      (dt_r_o),
  .rd_no       (rd_no),
  .wr_no       (wr_no),
  .den_no      (den_no),
  .done_o      (done_o)
);

// File: tb/busseq_top_test.sv
module busseq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  // {mem, wr, seg[1:0], if, nwait[2:0], addr[19:0], wdata[15:0], rbus[15:0]}
  localparam logic [59:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 2'd3, 1'b1, 3'd0, 20'hABCDE, 16'h0000, 16'h1234},
    {1'b1, 1'b1, 2'd0, 1'b0, 3'd2, 20'hF0001, 16'hBEEF, 16'h0000},
    {1'b0, 1'b0, 2'd2, 1'b1, 3'd1, 20'h5B000, 16'h0000, 16'h55AA},
    {1'b0, 1'b1, 2'd1, 1'b0, 3'd0, 20'hF00AB, 16'h00FF, 16'h0000},
    {1'b1, 1'b0, 2'd1, 1'b0, 3'd3, 20'h00123, 16'h0000, 16'hCAFE},
    {1'b1, 1'b1, 2'd2, 1'b1, 3'd1, 20'h80000, 16'h0F0F, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_mem = 1'b0, req_wr = 1'b0, req_if = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_seg = '0;
  logic [15:0] req_wdata = '0, bus_in = '0;
  logic        ready = 1'b1;
  logic        req_ready, ad_oe, ale, m_io, dt_r, rd_n, wr_n, den_n, done;
  logic [15:0] ad_out, rdata;
  logic [3:0]  as_out;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busseq_top uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_is_mem_i(req_mem), .req_is_write_i(req_wr), .req_addr_i(req_addr),
    .req_seg_i(req_seg), .req_if_flag_i(req_if), .req_wdata_i(req_wdata),
    .ready_i(ready), .bus_ad_o(ad_out), .bus_ad_oe_o(ad_oe), .bus_ad_i(bus_in),
    .bus_as_o(as_out), .ale_o(ale), .m_io_o(m_io), .dt_r_o(dt_r), .rd_no(rd_n),
    .wr_no(wr_n), .den_no(den_n), .rdata_o(rdata), .done_o(done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    check({tag, " ready"}, req_ready, 1);
    check({tag, " strobes"}, {ale, rd_n, wr_n, den_n, ad_oe, done}, 6'b011100);
  endtask

  // in-cycle strobe checks; strobe = T2/T3/TW
  task automatic check_phase(input string tag, input bit strobe, input bit mem, input bit wr,
                             input logic [3:0] stat, input logic [15:0] wd);
    check({tag, " R4 m_io"}, m_io, mem);
    check({tag, " R6/R7 dt_r"}, dt_r, wr);
    check({tag, " R6 rd_n"}, rd_n, !(strobe && !wr));
    check({tag, " R7 wr_n"}, wr_n, !(strobe && wr));
    check({tag, " R8 den_n"}, den_n, !strobe);
    check({tag, " R3 ale low"}, ale, 0);
    check({tag, " R5 status"}, as_out, stat);
    check({tag, " R6/R7 oe"}, ad_oe, wr);
    if (wr) check({tag, " R7 wdata"}, ad_out, wd);
  endtask

  task automatic run_cycle(input logic [59:0] v, input bit hold_valid);
    bit mem = v[59], wr = v[58], ifl = v[55];
    logic [1:0] seg = v[57:56];
    int nw = int'(v[54:52]);
    logic [19:0] addr = v[51:32];
    logic [15:0] wd = v[31:16], rb = v[15:0];
    logic [3:0] stat = {1'b0, ifl, seg};
    req_mem = mem; req_wr = wr; req_seg = seg; req_if = ifl;
    req_addr = addr; req_wdata = wd; bus_in = rb;
    req_valid = 1'b1; ready = (nw == 0);
    @(negedge clk); // T1
    if (!hold_valid) req_valid = 1'b0;
    check("R3 ale in T1", ale, 1);
    check("R3 oe in T1", ad_oe, 1);
    check("R3 low address", ad_out, addr[15:0]);
    check("R3/R4 upper lines", as_out, mem ? addr[19:16] : 4'h0);
    check("R4 m_io T1", m_io, mem);
    check("R6/R7 dt_r T1", dt_r, wr);
    check("R8 den T1", den_n, 1);
    check("R11 busy T1", req_ready, 0);
    check("R2 no done T1", done, 0);
    @(negedge clk); // T2
    check_phase("T2", 1, mem, wr, stat, wd);
    // scramble request inputs mid-cycle
    req_addr = ~addr; req_wdata = ~wd; req_seg = ~seg; req_if = ~ifl;
    req_mem = ~mem; req_wr = ~wr;
    @(negedge clk); // T3
    check_phase("T3", 1, mem, wr, stat, wd);
    check("R2 no done T3", done, 0);
    check("R11 busy T3", req_ready, 0);
    for (int k = 1; k <= nw; k++) begin
      @(negedge clk); // TW
      ready = (k == nw);
      check_phase("R9 wait", 1, mem, wr, stat, wd);
      check("R2 no done in wait", done, 0);
    end
    @(negedge clk); // T4
    check_phase("T4", 0, mem, wr, stat, wd);
    check("R2 done in T4", done, 1);
    check("R11 busy T4", req_ready, 0);
    if (!wr) check("R10 read data", rdata, rb);
    bus_in = ~rb;
    ready = 1'b1;
    @(negedge clk); // idle
    check_idle("R1 after cycle");
    check("R2 done single", done, 0);
    if (!wr) check("R10 read data held", rdata, rb);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 2);
    check_idle("R1 in reset");
    check("R10 rdata reset", rdata, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");
    for (int i = 0; i < NVEC; i++) run_cycle(VEC[i], 1'b0);

    // R11: valid held across a cycle, next T1 only after one idle
    run_cycle(VEC[2], 1'b1);
    run_cycle(VEC[5], 1'b0);

    // R10: a write does not disturb rdata held from the last read
    check("R10 rdata kept over write", rdata, 16'h55AA);

    // R1: asynchronous reset in the middle of a read
    req_mem = 1'b1; req_wr = 1'b0; req_addr = 20'h12345; ready = 1'b1; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    check("R6 rd low before reset", rd_n, 0);
    rst_n = 1'b0; #1;
    check_idle("R1 mid-cycle reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 stays idle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule